// File: doc/BRIEF.md
# Two-Stage Priority Arbiter for Transfer Channels

This block decides which of several transfer channels owns a shared bus. Each channel raises a request bit and carries a two-bit priority level set by software. The arbiter picks a winner in two stages. First, the highest level among the requesting channels wins. Second, if several channels share that level, the channel with the lowest index wins.

The channels sit in two groups. The primary group holds seven channels and the secondary group holds five. The secondary group is cascaded behind the primary one, so any primary request beats every secondary request, whatever their levels.

The grant is a registered one-hot vector. Once a channel is granted, it keeps the grant until the owner pulses `done`. The block arbitrates again on that edge, or on any edge while nothing is granted. To run with a single group, tie `req_b` to zero.

Top module: `dma_prio_arbiter`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it, both grant vectors are all zero.
- R2: Across `gnt_a` and `gnt_b` taken together, at most one grant bit is set in any cycle.
- R3: Channel i's level is `lvl_a[2i+1:2i]` (or `lvl_b[2i+1:2i]`). The encodings are 2'b11 very high, 2'b10 high, 2'b01 medium and 2'b00 low. Among the requesting channels of one group, a higher level wins.
- R4: Among requesting channels of equal top level in a group, the lowest index wins.
- R5: If any `req_a` bit is set when arbitration happens, the grant goes to the primary group, regardless of the secondary levels.
- R6: While a grant is held and `done` is low, the grant does not change. This holds even if the owner drops its request or a higher-level request arrives.
- R7: On an edge where a grant is held and `done` is high, the new grant is the winner among the requests present at that edge. This may be the same channel again.
- R8: While nothing is granted, the grant is updated on every edge to the current winner. A request withdrawn before it was granted never receives a grant.
- R9: If no channel requests at an arbitration edge, the grant becomes all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_a | input | N_A | Primary group request bits |
| lvl_a | input | 2*N_A | Primary group levels, two bits per channel |
| req_b | input | N_B | Secondary group request bits |
| lvl_b | input | 2*N_B | Secondary group levels, two bits per channel |
| done | input | 1 | Completion pulse from the granted channel |
| gnt_a | output | N_A | One-hot grant, primary group |
| gnt_b | output | N_B | One-hot grant, secondary group |

## Verification
The only state in the block is the grant register, so any internal error appears directly on `gnt_a`/`gnt_b`. A wrong comparison or a wrong group ordering shows as a wrong grant bit. It appears one edge after the arbitration edge where the fault occurs. A missing hold or a missing release shows as a grant that moves while `done` is low, or that stays put after `done`. The bench keeps a cycle-accurate model of the grant and compares it at every step. It uses directed cases for the ordering corners and a long pseudo-random sweep of requests, levels and `done`.

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter #(
  parameter int N_A = 7,
  parameter int N_B = 5,
  parameter int LW  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_A-1:0]    req_a,
  input  logic [LW*N_A-1:0] lvl_a,
  input  logic [N_B-1:0]    req_b,
  input  logic [LW*N_B-1:0] lvl_b,
  input  logic              done,
  output logic [N_A-1:0]    gnt_a,
  output logic [N_B-1:0]    gnt_b
);

  logic [N_A-1:0] win_a;
  logic [N_B-1:0] win_b;
  logic [LW-1:0]  top_a, top_b;
  logic           any_a, any_b;

  always_comb begin
    win_a = '0;
    top_a = '0;
    any_a = 1'b0;
    for (int i = 0; i < N_A; i++) begin
      if (req_a[i] && (!any_a || lvl_a[i*LW +: LW] > top_a)) begin
        any_a    = 1'b1;
        top_a    = lvl_a[i*LW +: LW];
        win_a    = '0;
        win_a[i] = 1'b1;
      end
    end
  end

  always_comb begin
    win_b = '0;
    top_b = '0;
    any_b = 1'b0;
    for (int i = 0; i < N_B; i++) begin
      if (req_b[i] && (!any_b || lvl_b[i*LW +: LW] > top_b)) begin
        any_b    = 1'b1;
        top_b    = lvl_b[i*LW +: LW];
        win_b    = '0;
        win_b[i] = 1'b1;
      end
    end
  end

  wire idle = ~(|gnt_a) & ~(|gnt_b);
  wire rearb = idle | done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_a <= '0;
      gnt_b <= '0;
    end else if (rearb) begin
      gnt_a <= win_a;
      gnt_b <= any_a ? '0 : win_b;
    end
  end

endmodule

module dma_prio_arbiter_chk #(
  parameter int N_A = 7,
  parameter int N_B = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N_A-1:0] req_a,
  input logic [N_B-1:0] req_b,
  input logic           done,
  input logic [N_A-1:0] gnt_a,
  input logic [N_B-1:0] gnt_b
);
  wire [N_A+N_B-1:0] g = {gnt_b, gnt_a};
  wire [N_A+N_B-1:0] r = {req_b, req_a};
  wire free = (g == '0) || done;

  // R2
  one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(g));

  // R6
  hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (g != '0 && !done) |=> $stable(g));

  // R8
  granted_was_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free |=> (g == '0 || (g & $past(r)) != '0));

  // R5
  primary_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free && req_a != '0) |=> (gnt_a != '0 && gnt_b == '0));

  // R9
  empty_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free && r == '0) |=> g == '0);
endmodule

bind dma_prio_arbiter dma_prio_arbiter_chk #(.N_A(N_A), .N_B(N_B)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_a(req_a), .req_b(req_b),
  .done(done), .gnt_a(gnt_a), .gnt_b(gnt_b)
);

// File: tb/dma_prio_arbiter_tb.sv
module dma_prio_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  req_a = '0;
  logic [13:0] lvl_a = '0;
  logic [4:0]  req_b = '0;
  logic [9:0]  lvl_b = '0;
  logic        done = 1'b0;
  logic [6:0]  gnt_a;
  logic [4:0]  gnt_b;
  logic [11:0] model = '0;
  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  dma_prio_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .req_a(req_a), .lvl_a(lvl_a),
    .req_b(req_b), .lvl_b(lvl_b), .done(done),
    .gnt_a(gnt_a), .gnt_b(gnt_b)
  );

  function automatic logic [11:0] pick(input logic [6:0] ra, input logic [13:0] la,
                                       input logic [4:0] rb, input logic [9:0] lb);
    int best = -1;
    int idx = -1;
    for (int i = 0; i < 7; i++)
      if (ra[i] && int'(la[2*i +: 2]) > best) begin best = int'(la[2*i +: 2]); idx = i; end
    if (idx >= 0) return 12'(1) << idx;
    for (int i = 0; i < 5; i++)
      if (rb[i] && int'(lb[2*i +: 2]) > best) begin best = int'(lb[2*i +: 2]); idx = i; end
    if (idx >= 0) return 12'(1) << (7 + idx);
    return '0;
  endfunction

  task automatic check(input string tag, input logic [11:0] exp);
    checks++;
    if ({gnt_b, gnt_a} !== exp) begin
      errors++;
      $display("FAIL %s: grant=%h expected=%h", tag, {gnt_b, gnt_a}, exp);
    end
  endtask

  task automatic step(input logic [6:0] ra, input logic [13:0] la,
                      input logic [4:0] rb, input logic [9:0] lb,
                      input logic d, input string tag);
    req_a = ra; lvl_a = la; req_b = rb; lvl_b = lb; done = d;
    if (model == '0 || d) model = pick(ra, la, rb, lb);
    @(negedge clk);
    check(tag, model);
    checks++;
    if ($countones({gnt_b, gnt_a}) > 1) begin
      errors++;
      $display("FAIL R2: grant=%h expected at most one bit", {gnt_b, gnt_a});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 during reset", '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", '0);
    // R3: ch5 very high beats ch2 medium
    step(7'b0100100, (14'd3 << 10) | (14'd1 << 4), '0, '0, 0, "R3");
    // R6: higher arrivals do not preempt
    step(7'b0100101, 14'd3 | (14'd3 << 4) | (14'd3 << 10), '0, '0, 0, "R6");
    // R4 with R7: ch0 and ch2 tie at very high
    step(7'b0000101, 14'd3 | (14'd3 << 4), '0, '0, 1, "R4");
    step('0, '0, '0, '0, 0, "R6 owner dropped");
    step('0, '0, '0, '0, 1, "R9");
    // R5: low primary beats very high secondary
    step(7'b0001000, '0, 5'b00001, 10'd3, 0, "R5");
    step('0, '0, 5'b10010, (10'd2 << 2) | (10'd2 << 8), 1, "R4 secondary");
    step('0, '0, '0, '0, 1, "R9 secondary");
    // R8: waiting ch6 withdrawn before release
    step(7'b0000010, '0, '0, '0, 0, "R8 grant ch1");
    step(7'b1000010, 14'd3 << 12, '0, '0, 0, "R8 ch6 waits");
    step(7'b0000010, '0, '0, '0, 0, "R8 ch6 withdrawn");
    step('0, '0, '0, '0, 1, "R8 no late grant");
    step(7'b0000010, '0, '0, '0, 1, "R7 same channel");
    step(7'b0000010, '0, '0, '0, 1, "R7 regrant again");
    for (int k = 0; k < 4000; k++) begin
      logic [6:0] ra; logic [4:0] rb; logic [13:0] la; logic [9:0] lb; logic d;
      seed = seed * 32'd1664525 + 32'd1013904223; ra = seed[31:25] & seed[24:18];
      seed = seed * 32'd1664525 + 32'd1013904223; la = seed[31:18];
      seed = seed * 32'd1664525 + 32'd1013904223; rb = seed[31:27]; lb = seed[26:17]; d = seed[16] & seed[15];
      step(ra, la, rb, lb, d, "R7 sweep");
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: expired, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule